// File: doc/BRIEF.md
# MSI L1 Line Coherence Controller

This block keeps the coherence state of one L1 cache line under a three-state MSI protocol that works with a directory. Each cycle it accepts at most one event from three input streams: directory responses, forwarded requests, and CPU requests. It then moves the line through its stable and transient states and emits the protocol messages, hit callbacks, fill strobes and eviction notices that the event calls for.

Invalidation acknowledgements for a pending write are counted in a small wrapping counter. Acks may arrive before the directory's data, which drives the counter negative, or after it, when the data has loaded the expected count. Any event that the current transient state cannot handle is refused through the ready signal of its stream and waits at the head of that stream. Data payloads are opaque. Outgoing data comes from the `line_data` port, which the surrounding data array supplies. Incoming fill data is handed back through `fill_data`.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 (I), every output strobe is low, and a CPU load is ready. State codes: I=0, S=1, M=2, IS_D=3, IM_AD=4, IM_A=5, SM_AD=6, SM_A=7, MI_A=8, SI_A=9, II_A=10.
- R2: CPU ops are load=0, store=1, replace=2. A load accepted in I issues a GetS request (`req_kind` 0) and enters IS_D. A store in I issues GetM (`req_kind` 1) and enters IM_AD.
- R3: Response kinds are data-no-acks=0, data-with-acks=1, data-from-owner=2, inv-ack=3. In IS_D, data kind 0 or 2 enters S and raises `fill_valid` with `fill_data` equal to `resp_data`. It also raises a load hit (`hit_valid`=1, `hit_store`=0, `hit_miss`=1).
- R4: In IM_AD or SM_AD, data kind 0 or 2 enters M with a store miss hit. Data kind 1 adds `resp_acks` to the ack counter and enters IM_A or SM_A. If that sum is zero, because the acks already came, it enters M at once with a store hit.
- R5: Each inv-ack in IM_AD, IM_A, SM_AD or SM_A lowers the counter by one. The inv-ack that finds the counter at 1 in IM_A or SM_A enters M with a store miss hit.
- R6: Forward kinds are FwdGetS=0, FwdGetM=1, Inv=2, PutAck=3. In M, FwdGetS sends one Data response (`rsp_kind` 0) carrying `line_data` to both the requestor (`rsp_dest` = `fwd_src`) and the directory, and enters S. FwdGetM sends Data to the requestor only, enters I and pulses `free_line`.
- R7: A replace in S sends PutS (`req_kind` 2) and enters SI_A. A replace in M sends PutM (`req_kind` 3) with `req_data` = `line_data` and enters MI_A. PutAck in MI_A, SI_A or II_A enters I and pulses `free_line`.
- R8: In MI_A, FwdGetS sends Data to the requestor and the directory and enters SI_A, and FwdGetM sends Data to the requestor and enters II_A. In SI_A, Inv sends an inv-ack (`rsp_kind` 1) to the requestor and enters II_A.
- R9: Inv in S sends an inv-ack to `fwd_src`, enters I and pulses `free_line`. Inv in SM_AD sends an inv-ack and enters IM_AD.
- R10: Responses are always taken first. A forward is taken only with no response present, and a CPU op only with neither present. Stall rules:
  - IS_D refuses CPU ops and Inv.
  - IM_AD and IM_A refuse CPU ops, FwdGetS and FwdGetM.
  - SM_AD and SM_A refuse stores, replaces, FwdGetS and FwdGetM, but a load hits there.
  - MI_A, SI_A and II_A refuse CPU ops.
- R11: `req_has_data` is 1 only for PutM. Data responses carry `line_data`, and inv-acks carry zero data.
- R12: `evict_valid` pulses on a replace in S or M, on Inv in S and on Inv in SM_AD, and only when the parameter EVICT_EN is nonzero.
- R13: A data-with-acks response carrying zero acks, or any accepted event with no defined transition, pulses `proto_err` and leaves the state unchanged.
- R14: Every output strobe is registered. It appears in the cycle after the accepting clock edge, together with the new `line_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | CPU request present |
| cpu_op | input | 2 | CPU op: load, store, replace |
| cpu_ready | output | 1 | CPU request accepted this cycle if valid |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_kind | input | 2 | FwdGetS, FwdGetM, Inv, PutAck |
| fwd_src | input | ID_W | Requestor id of the forward |
| fwd_ready | output | 1 | Forward accepted this cycle if valid |
| resp_valid | input | 1 | Response present (always accepted) |
| resp_kind | input | 2 | Response kind |
| resp_acks | input | ACK_W | Ack count of a data-with-acks response |
| resp_data | input | DATA_W | Response data block |
| line_data | input | DATA_W | Current contents of the line |
| req_valid | output | 1 | Request message to the directory |
| req_kind | output | 2 | GetS, GetM, PutS, PutM |
| req_has_data | output | 1 | Request is data-sized |
| req_data | output | DATA_W | Request data block |
| rsp_valid | output | 1 | Response message out |
| rsp_kind | output | 1 | 0 Data, 1 inv-ack |
| rsp_to_req | output | 1 | Destined for the requestor |
| rsp_to_dir | output | 1 | Destined for the directory |
| rsp_dest | output | ID_W | Requestor id |
| rsp_data | output | DATA_W | Response data block |
| hit_valid | output | 1 | Hit callback to the CPU |
| hit_store | output | 1 | Callback is for a store |
| hit_miss | output | 1 | Callback completes a miss |
| fill_valid | output | 1 | Write `fill_data` into the line |
| fill_data | output | DATA_W | Fill data block |
| evict_valid | output | 1 | Eviction notice to the CPU |
| free_line | output | 1 | The line may be released |
| proto_err | output | 1 | Protocol error pulse |
| line_state | output | 4 | Current state code |

## Verification
The write path is tried with the acks arriving after the data, which goes through IM_A. It is also tried with the acks arriving before the data, where the counter goes negative and the data response then completes in one step. Together these two orders separate a counter that is added and decremented correctly from one that only counts down. The read path, the upgrade lost to an Inv, and both eviction chains are each followed down to I. Simultaneous inputs on several streams show the priority order and the blocking of lower streams by a stalled forward. Zero-ack data and an unexpected forward in I check the error pulse. A second instance with eviction notices disabled sees the same stimulus and must never raise one.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [3:0] {
      ST_I = 4'd0, ST_S = 4'd1, ST_M = 4'd2, ST_IS_D = 4'd3,
      ST_IM_AD = 4'd4, ST_IM_A = 4'd5, ST_SM_AD = 4'd6, ST_SM_A = 4'd7,
      ST_MI_A = 4'd8, ST_SI_A = 4'd9, ST_II_A = 4'd10
   } line_st_e;

   localparam logic [1:0] OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_REPL = 2'd2;
   localparam logic [1:0] FW_GETS = 2'd0, FW_GETM = 2'd1, FW_INV = 2'd2, FW_PUTACK = 2'd3;
   localparam logic [1:0] RS_DNOACK = 2'd0, RS_DACKS = 2'd1, RS_DOWNER = 2'd2, RS_INVACK = 2'd3;
   localparam logic [1:0] RQ_GETS = 2'd0, RQ_GETM = 2'd1, RQ_PUTS = 2'd2, RQ_PUTM = 2'd3;
   localparam logic       OUT_DATA = 1'b0, OUT_INVACK = 1'b1;

   typedef struct packed {
      logic       req_v;
      logic [1:0] req_k;
      logic       rsp_v;
      logic       rsp_k;
      logic       to_req;
      logic       to_dir;
      logic       hit_v;
      logic       hit_st;
      logic       hit_miss;
      logic       evict;
      logic       fill;
      logic       free_l;
      logic       err;
      logic       cnt_clr;
      logic       cnt_dec;
      logic       cnt_add;
   } act_t;
endpackage

// File: rtl/msi_ack_ctr.sv
module msi_ack_ctr #(
   parameter int ACK_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             dec,
   input  logic             add,
   input  logic [ACK_W-1:0] add_val,
   output logic [ACK_W-1:0] sum,
   output logic             sum_zero,
   output logic             cnt_one
);
   logic [ACK_W-1:0] cnt_q;
   localparam logic [ACK_W-1:0] ONE = ACK_W'(1);

   assign sum      = cnt_q + add_val;
   assign sum_zero = (sum == '0);
   assign cnt_one  = (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (add) cnt_q <= sum;
      else if (dec) cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
   import msi_pkg::*;
(
   input  line_st_e   st,
   input  logic       resp_valid,
   input  logic [1:0] resp_kind,
   input  logic       acks_zero,
   input  logic       sum_zero,
   input  logic       cnt_one,
   input  logic       fwd_valid,
   input  logic [1:0] fwd_kind,
   input  logic       cpu_valid,
   input  logic [1:0] cpu_op,
   output line_st_e   nxt,
   output act_t       act,
   output logic       fwd_ready,
   output logic       cpu_ready
);
   logic fwd_stall, cpu_stall, fwd_get;

   assign fwd_get = (fwd_kind == FW_GETS) || (fwd_kind == FW_GETM);

   always_comb begin
      unique case (st)
         ST_IS_D:                    fwd_stall = (fwd_kind == FW_INV);
         ST_IM_AD, ST_IM_A,
         ST_SM_AD, ST_SM_A:          fwd_stall = fwd_get;
         default:                    fwd_stall = 1'b0;
      endcase
      unique case (st)
         ST_IS_D, ST_IM_AD, ST_IM_A,
         ST_MI_A, ST_SI_A, ST_II_A:  cpu_stall = 1'b1;
         ST_SM_AD, ST_SM_A:          cpu_stall = (cpu_op != OP_LOAD);
         default:                    cpu_stall = 1'b0;
      endcase
   end

   assign fwd_ready = !resp_valid && !fwd_stall;
   assign cpu_ready = !resp_valid && !fwd_valid && !cpu_stall;

   always_comb begin
      nxt = st;
      act = '0;
      if (resp_valid) begin
         unique case (st)
            ST_IS_D: begin
               if (resp_kind == RS_DNOACK || resp_kind == RS_DOWNER) begin
                  nxt = ST_S; act.fill = 1'b1; act.hit_v = 1'b1; act.hit_miss = 1'b1;
               end else act.err = 1'b1;
            end
            ST_IM_AD, ST_SM_AD: begin
               if (resp_kind == RS_INVACK) act.cnt_dec = 1'b1;
               else if (resp_kind == RS_DACKS) begin
                  if (acks_zero) act.err = 1'b1;
                  else begin
                     act.fill = 1'b1;
                     if (sum_zero) begin
                        nxt = ST_M; act.hit_v = 1'b1; act.hit_st = 1'b1;
                        act.hit_miss = 1'b1; act.cnt_clr = 1'b1;
                     end else begin
                        nxt = (st == ST_IM_AD) ? ST_IM_A : ST_SM_A; act.cnt_add = 1'b1;
                     end
                  end
               end else begin
                  nxt = ST_M; act.fill = 1'b1; act.hit_v = 1'b1; act.hit_st = 1'b1;
                  act.hit_miss = 1'b1; act.cnt_clr = 1'b1;
               end
            end
            ST_IM_A, ST_SM_A: begin
               if (resp_kind != RS_INVACK) act.err = 1'b1;
               else if (cnt_one) begin
                  nxt = ST_M; act.hit_v = 1'b1; act.hit_st = 1'b1;
                  act.hit_miss = 1'b1; act.cnt_clr = 1'b1;
               end else act.cnt_dec = 1'b1;
            end
            default: act.err = 1'b1;
         endcase
      end else if (fwd_valid && !fwd_stall) begin
         unique case (st)
            ST_S, ST_SM_AD, ST_SI_A: begin
               if (fwd_kind == FW_INV) begin
                  act.rsp_v = 1'b1; act.rsp_k = OUT_INVACK; act.to_req = 1'b1;
                  act.evict = (st != ST_SI_A);
                  act.free_l = (st == ST_S);
                  nxt = (st == ST_S) ? ST_I : (st == ST_SM_AD) ? ST_IM_AD : ST_II_A;
               end else if (fwd_kind == FW_PUTACK && st == ST_SI_A) begin
                  nxt = ST_I; act.free_l = 1'b1;
               end else act.err = 1'b1;
            end
            ST_M, ST_MI_A: begin
               if (fwd_get) begin
                  act.rsp_v = 1'b1; act.rsp_k = OUT_DATA; act.to_req = 1'b1;
                  act.to_dir = (fwd_kind == FW_GETS);
                  if (st == ST_M) begin
                     nxt = (fwd_kind == FW_GETS) ? ST_S : ST_I;
                     act.free_l = (fwd_kind == FW_GETM);
                  end else nxt = (fwd_kind == FW_GETS) ? ST_SI_A : ST_II_A;
               end else if (fwd_kind == FW_PUTACK && st == ST_MI_A) begin
                  nxt = ST_I; act.free_l = 1'b1;
               end else act.err = 1'b1;
            end
            ST_II_A: begin
               if (fwd_kind == FW_PUTACK) begin nxt = ST_I; act.free_l = 1'b1; end
               else act.err = 1'b1;
            end
            default: act.err = 1'b1;
         endcase
      end else if (cpu_valid && !fwd_valid && !cpu_stall) begin
         unique case (st)
            ST_I: begin
               if (cpu_op == OP_LOAD) begin
                  nxt = ST_IS_D; act.req_v = 1'b1; act.req_k = RQ_GETS;
               end else if (cpu_op == OP_STORE) begin
                  nxt = ST_IM_AD; act.req_v = 1'b1; act.req_k = RQ_GETM;
               end else if (cpu_op != OP_REPL) act.err = 1'b1;
            end
            ST_S, ST_M: begin
               if (cpu_op == OP_LOAD) act.hit_v = 1'b1;
               else if (cpu_op == OP_STORE && st == ST_M) begin
                  act.hit_v = 1'b1; act.hit_st = 1'b1;
               end else if (cpu_op == OP_STORE) begin
                  nxt = ST_SM_AD; act.req_v = 1'b1; act.req_k = RQ_GETM;
               end else if (cpu_op == OP_REPL) begin
                  nxt = (st == ST_S) ? ST_SI_A : ST_MI_A; act.req_v = 1'b1;
                  act.req_k = (st == ST_S) ? RQ_PUTS : RQ_PUTM; act.evict = 1'b1;
               end else act.err = 1'b1;
            end
            ST_SM_AD, ST_SM_A: act.hit_v = 1'b1;
            default: act.err = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/msi_msg_reg.sv
module msi_msg_reg
   import msi_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  act_t              act,
   input  logic [DATA_W-1:0] line_data,
   input  logic [DATA_W-1:0] resp_data,
   input  logic [ID_W-1:0]   fwd_src,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic              req_has_data,
   output logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   output logic              rsp_kind,
   output logic              rsp_to_req,
   output logic              rsp_to_dir,
   output logic [ID_W-1:0]   rsp_dest,
   output logic [DATA_W-1:0] rsp_data,
   output logic              hit_valid,
   output logic              hit_store,
   output logic              hit_miss,
   output logic              fill_valid,
   output logic [DATA_W-1:0] fill_data,
   output logic              evict_valid,
   output logic              free_line,
   output logic              proto_err
);
   logic put_data;
   assign put_data = act.req_v && (act.req_k == RQ_PUTM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0; req_kind <= '0; req_has_data <= 1'b0; req_data <= '0;
         rsp_valid <= 1'b0; rsp_kind <= 1'b0; rsp_to_req <= 1'b0; rsp_to_dir <= 1'b0;
         rsp_dest <= '0; rsp_data <= '0;
         hit_valid <= 1'b0; hit_store <= 1'b0; hit_miss <= 1'b0;
         fill_valid <= 1'b0; fill_data <= '0;
         evict_valid <= 1'b0; free_line <= 1'b0; proto_err <= 1'b0;
      end else begin
         req_valid    <= act.req_v;
         req_kind     <= act.req_k;
         req_has_data <= put_data;
         req_data     <= put_data ? line_data : '0;
         rsp_valid    <= act.rsp_v;
         rsp_kind     <= act.rsp_k;
         rsp_to_req   <= act.to_req;
         rsp_to_dir   <= act.to_dir;
         rsp_dest     <= act.rsp_v ? fwd_src : '0;
         rsp_data     <= (act.rsp_v && act.rsp_k == OUT_DATA) ? line_data : '0;
         hit_valid    <= act.hit_v;
         hit_store    <= act.hit_st;
         hit_miss     <= act.hit_miss;
         fill_valid   <= act.fill;
         fill_data    <= act.fill ? resp_data : '0;
         evict_valid  <= act.evict;
         free_line    <= act.free_l;
         proto_err    <= act.err;
      end
   end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
   import msi_pkg::*;
#(
   parameter int ACK_W    = 4,
   parameter int DATA_W   = 64,
   parameter int ID_W     = 4,
   parameter int EVICT_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic [1:0]        cpu_op,
   output logic              cpu_ready,
   input  logic              fwd_valid,
   input  logic [1:0]        fwd_kind,
   input  logic [ID_W-1:0]   fwd_src,
   output logic              fwd_ready,
   input  logic              resp_valid,
   input  logic [1:0]        resp_kind,
   input  logic [ACK_W-1:0]  resp_acks,
   input  logic [DATA_W-1:0] resp_data,
   input  logic [DATA_W-1:0] line_data,
   output logic              req_valid,
   output logic [1:0]        req_kind,
   output logic              req_has_data,
   output logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   output logic              rsp_kind,
   output logic              rsp_to_req,
   output logic              rsp_to_dir,
   output logic [ID_W-1:0]   rsp_dest,
   output logic [DATA_W-1:0] rsp_data,
   output logic              hit_valid,
   output logic              hit_store,
   output logic              hit_miss,
   output logic              fill_valid,
   output logic [DATA_W-1:0] fill_data,
   output logic              evict_valid,
   output logic              free_line,
   output logic              proto_err,
   output logic [3:0]        line_state
);
   if (ACK_W < 2 || DATA_W < 1 || ID_W < 1) begin : g_bad_cfg
      $error("msi_line_ctrl: ACK_W must be at least 2, DATA_W and ID_W at least 1");
   end

   line_st_e         st_q, st_nxt;
   act_t             act_raw, act_eff;
   logic [ACK_W-1:0] ack_sum;
   logic             sum_zero, cnt_one;

   msi_ack_ctr #(.ACK_W(ACK_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(act_raw.cnt_clr), .dec(act_raw.cnt_dec),
      .add(act_raw.cnt_add), .add_val(resp_acks), .sum(ack_sum),
      .sum_zero(sum_zero), .cnt_one(cnt_one)
   );

   msi_line_fsm u_fsm (
      .st(st_q), .resp_valid(resp_valid), .resp_kind(resp_kind),
      .acks_zero(resp_acks == '0), .sum_zero(sum_zero), .cnt_one(cnt_one),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .cpu_valid(cpu_valid),
      .cpu_op(cpu_op), .nxt(st_nxt), .act(act_raw),
      .fwd_ready(fwd_ready), .cpu_ready(cpu_ready)
   );

   if (EVICT_EN != 0) begin : g_evict_on
      assign act_eff = act_raw;
   end else begin : g_evict_off
      always_comb begin
         act_eff       = act_raw;
         act_eff.evict = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_I;
      else        st_q <= st_nxt;
   end

   assign line_state = st_q;

   msi_msg_reg #(.DATA_W(DATA_W), .ID_W(ID_W)) u_out (
      .clk(clk), .rst_n(rst_n), .act(act_eff), .line_data(line_data),
      .resp_data(resp_data), .fwd_src(fwd_src),
      .req_valid(req_valid), .req_kind(req_kind), .req_has_data(req_has_data),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
      .rsp_to_req(rsp_to_req), .rsp_to_dir(rsp_to_dir), .rsp_dest(rsp_dest),
      .rsp_data(rsp_data), .hit_valid(hit_valid), .hit_store(hit_store),
      .hit_miss(hit_miss), .fill_valid(fill_valid), .fill_data(fill_data),
      .evict_valid(evict_valid), .free_line(free_line), .proto_err(proto_err)
   );
endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_valid,
   input logic [1:0] cpu_op,
   input logic       cpu_ready,
   input logic       fwd_valid,
   input logic [1:0] fwd_kind,
   input logic       fwd_ready,
   input logic       resp_valid,
   input logic [1:0] resp_kind,
   input logic [3:0] resp_acks_nz,
   input logic       req_valid,
   input logic [1:0] req_kind,
   input logic       rsp_valid,
   input logic       rsp_kind,
   input logic       rsp_to_req,
   input logic       rsp_to_dir,
   input logic       hit_valid,
   input logic       hit_store,
   input logic       free_line,
   input logic       proto_err,
   input logic [3:0] line_state
);
   logic cpu_acc, fwd_acc;
   assign cpu_acc = cpu_valid && cpu_ready;
   assign fwd_acc = fwd_valid && fwd_ready;

   AST_LOAD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_acc && cpu_op == 2'd0 && line_state == 4'd0 |=> req_valid && req_kind == 2'd0 && line_state == 4'd3); // R2
   AST_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && line_state == 4'd3 && (resp_kind == 2'd0 || resp_kind == 2'd2)
      |=> hit_valid && !hit_store && line_state == 4'd1); // R3
   AST_FWDS_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_acc && fwd_kind == 2'd0 && line_state == 4'd2 |=> rsp_valid && rsp_to_req && rsp_to_dir && line_state == 4'd1); // R6
   AST_REPL_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_acc && cpu_op == 2'd2 && line_state == 4'd2 |=> req_valid && req_kind == 2'd3 && line_state == 4'd8); // R7
   AST_PUTACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_acc && fwd_kind == 2'd3 && (line_state == 4'd8 || line_state == 4'd9 || line_state == 4'd10)
      |=> line_state == 4'd0 && free_line); // R7
   AST_INV_IN_S: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_acc && fwd_kind == 2'd2 && line_state == 4'd1 |=> rsp_valid && rsp_kind && line_state == 4'd0); // R9
   AST_IS_D_HOLDS_INV: assert property (@(posedge clk) disable iff (!rst_n)
      line_state == 4'd3 && fwd_valid && fwd_kind == 2'd2 |-> !fwd_ready); // R10
   AST_ZERO_ACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_kind == 2'd1 && resp_acks_nz == 4'd0 |=> proto_err); // R13
endmodule

bind msi_line_ctrl msi_line_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
   .cpu_ready(cpu_ready), .fwd_valid(fwd_valid), .fwd_kind(fwd_kind),
   .fwd_ready(fwd_ready), .resp_valid(resp_valid), .resp_kind(resp_kind),
   .resp_acks_nz(4'(resp_acks)), .req_valid(req_valid), .req_kind(req_kind),
   .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_to_req(rsp_to_req),
   .rsp_to_dir(rsp_to_dir), .hit_valid(hit_valid), .hit_store(hit_store),
   .free_line(free_line), .proto_err(proto_err), .line_state(line_state)
);

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cpu_valid = 0, fwd_valid = 0, resp_valid = 0;
   logic [1:0]  cpu_op = 0, fwd_kind = 0, resp_kind = 0;
   logic [3:0]  fwd_src = 0, resp_acks = 0;
   logic [63:0] resp_data = 0, line_data = 0;

   logic cpu_ready, fwd_ready, req_valid, req_has_data, rsp_valid, rsp_kind;
   logic rsp_to_req, rsp_to_dir, hit_valid, hit_store, hit_miss, fill_valid;
   logic evict_valid, free_line, proto_err;
   logic [1:0]  req_kind;
   logic [3:0]  rsp_dest, line_state;
   logic [63:0] req_data, rsp_data, fill_data;

   logic cpu_ready_n, fwd_ready_n, req_valid_n, req_has_data_n, rsp_valid_n, rsp_kind_n;
   logic rsp_to_req_n, rsp_to_dir_n, hit_valid_n, hit_store_n, hit_miss_n, fill_valid_n;
   logic evict_valid_n, free_line_n, proto_err_n;
   logic [1:0]  req_kind_n;
   logic [3:0]  rsp_dest_n, line_state_n;
   logic [63:0] req_data_n, rsp_data_n, fill_data_n;

   msi_line_ctrl i_msi_line_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_src(fwd_src), .fwd_ready(fwd_ready),
      .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_acks(resp_acks),
      .resp_data(resp_data), .line_data(line_data), .req_valid(req_valid),
      .req_kind(req_kind), .req_has_data(req_has_data), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_to_req(rsp_to_req),
      .rsp_to_dir(rsp_to_dir), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
      .hit_valid(hit_valid), .hit_store(hit_store), .hit_miss(hit_miss),
      .fill_valid(fill_valid), .fill_data(fill_data), .evict_valid(evict_valid),
      .free_line(free_line), .proto_err(proto_err), .line_state(line_state));

   msi_line_ctrl #(.EVICT_EN(0)) i_msi_line_ctrl_noev (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready_n),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_src(fwd_src), .fwd_ready(fwd_ready_n),
      .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_acks(resp_acks),
      .resp_data(resp_data), .line_data(line_data), .req_valid(req_valid_n),
      .req_kind(req_kind_n), .req_has_data(req_has_data_n), .req_data(req_data_n),
      .rsp_valid(rsp_valid_n), .rsp_kind(rsp_kind_n), .rsp_to_req(rsp_to_req_n),
      .rsp_to_dir(rsp_to_dir_n), .rsp_dest(rsp_dest_n), .rsp_data(rsp_data_n),
      .hit_valid(hit_valid_n), .hit_store(hit_store_n), .hit_miss(hit_miss_n),
      .fill_valid(fill_valid_n), .fill_data(fill_data_n), .evict_valid(evict_valid_n),
      .free_line(free_line_n), .proto_err(proto_err_n), .line_state(line_state_n));

   int n_chk = 0, n_fail = 0;
   logic cpu_rdy_s, fwd_rdy_s, noev_seen = 1'b0;

   always @(posedge clk) if (rst_n && evict_valid_n) noev_seen <= 1'b1;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic cv, input logic [1:0] cop, input logic fv, input logic [1:0] fk,
                        input logic [3:0] fs, input logic rv, input logic [1:0] rk,
                        input logic [3:0] ra, input logic [63:0] rd);
      @(negedge clk);
      cpu_valid = cv; cpu_op = cop; fwd_valid = fv; fwd_kind = fk; fwd_src = fs;
      resp_valid = rv; resp_kind = rk; resp_acks = ra; resp_data = rd;
      #1;
      cpu_rdy_s = cpu_ready; fwd_rdy_s = fwd_ready;
      @(negedge clk);
      cpu_valid = 0; fwd_valid = 0; resp_valid = 0;
   endtask

   task automatic cpu(input logic [1:0] op);
      drive(1, op, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic fwd(input logic [1:0] k, input logic [3:0] s);
      drive(0, 0, 1, k, s, 0, 0, 0, 0);
   endtask
   task automatic resp(input logic [1:0] k, input logic [3:0] a, input logic [63:0] d);
      drive(0, 0, 0, 0, 0, 1, k, a, d);
   endtask

   task automatic t_reset;
      chk("R1 state", line_state, 0);
      chk("R1 strobes", {req_valid, rsp_valid, hit_valid, fill_valid, evict_valid, proto_err}, 0);
      chk("R1 cpu_ready", cpu_ready, 1);
   endtask

   task automatic t_read_miss;
      cpu(0);
      chk("R2 GetS", {req_valid, req_kind, req_has_data}, {1'b1, 2'd0, 1'b0});
      chk("R14 state IS_D", line_state, 3);
      cpu(0);
      chk("R10 IS_D holds load", cpu_rdy_s, 0);
      chk("R10 no request", req_valid, 0);
      resp(2, 0, 64'hA5A5);
      chk("R3 state S", line_state, 1);
      chk("R3 hit", {hit_valid, hit_store, hit_miss}, 3'b101);
      chk("R3 fill", {fill_valid, fill_data}, {1'b1, 64'hA5A5});
      cpu(0);
      chk("R3 plain hit", {hit_valid, hit_miss}, 2'b10);
      fwd(2, 5);
      chk("R9 inv-ack", {rsp_valid, rsp_kind, rsp_to_req, rsp_to_dir, rsp_dest}, {4'b1110, 4'd5});
      chk("R11 inv-ack data", rsp_data, 0);
      chk("R9 state I", {line_state, free_line}, {4'd0, 1'b1});
      chk("R12 evict on Inv in S", evict_valid, 1);
   endtask

   task automatic t_write_acks_after;
      cpu(1);
      chk("R2 GetM", {req_valid, req_kind}, {1'b1, 2'd1});
      chk("R2 state IM_AD", line_state, 4);
      resp(1, 2, 64'h1111);
      chk("R4 state IM_A", {line_state, hit_valid, fill_valid}, {4'd5, 1'b0, 1'b1});
      resp(3, 0, 0);
      chk("R5 still IM_A", {line_state, hit_valid}, {4'd5, 1'b0});
      resp(3, 0, 0);
      chk("R5 last ack to M", line_state, 2);
      chk("R5 store hit", {hit_valid, hit_store, hit_miss}, 3'b111);
      cpu(1);
      chk("R5 store hit in M", {hit_valid, hit_store, hit_miss}, 3'b110);
      line_data = 64'hBEEF;
      fwd(0, 3);
      chk("R6 data both", {rsp_valid, rsp_kind, rsp_to_req, rsp_to_dir, rsp_dest}, {4'b1011, 4'd3});
      chk("R11 data carried", rsp_data, 64'hBEEF);
      chk("R6 state S", line_state, 1);
   endtask

   task automatic t_upgrade_acks_first;
      cpu(1);
      chk("R2 upgrade GetM", {req_valid, req_kind, line_state}, {1'b1, 2'd1, 4'd6});
      cpu(0);
      chk("R10 load hits in SM_AD", {cpu_rdy_s, hit_valid, hit_miss, line_state}, {3'b110, 4'd6});
      resp(3, 0, 0);
      resp(3, 0, 0);
      chk("R5 acks before data", {line_state, hit_valid}, {4'd6, 1'b0});
      resp(1, 2, 64'h2222);
      chk("R4 zero sum to M", {line_state, hit_valid, hit_store}, {4'd2, 2'b11});
      fwd(1, 7);
      chk("R6 FwdGetM", {rsp_valid, rsp_kind, rsp_to_req, rsp_to_dir, rsp_dest}, {4'b1010, 4'd7});
      chk("R6 to I", {line_state, free_line}, {4'd0, 1'b1});
   endtask

   task automatic t_upgrade_lost;
      cpu(0);
      resp(0, 0, 64'h3);
      chk("R3 no-ack data to S", line_state, 1);
      cpu(1);
      fwd(2, 2);
      chk("R9 Inv in SM_AD", {rsp_valid, rsp_kind, rsp_dest, line_state}, {2'b11, 4'd2, 4'd4});
      chk("R12 evict on Inv in SM_AD", evict_valid, 1);
      cpu(1);
      chk("R10 IM_AD holds store", cpu_rdy_s, 0);
      resp(1, 0, 0);
      chk("R13 zero acks", {proto_err, line_state}, {1'b1, 4'd4});
      resp(0, 0, 64'h4);
      chk("R4 no-ack data to M", {line_state, hit_valid, hit_store}, {4'd2, 2'b11});
   endtask

   task automatic t_evict_m;
      line_data = 64'hCAFE;
      cpu(2);
      chk("R7 PutM", {req_valid, req_kind, req_has_data}, {1'b1, 2'd3, 1'b1});
      chk("R11 PutM data", req_data, 64'hCAFE);
      chk("R7 state MI_A", {line_state, evict_valid}, {4'd8, 1'b1});
      cpu(0);
      chk("R10 MI_A holds load", cpu_rdy_s, 0);
      fwd(0, 4);
      chk("R8 FwdGetS in MI_A", {rsp_valid, rsp_to_req, rsp_to_dir, line_state}, {3'b111, 4'd9});
      chk("R8 data", rsp_data, 64'hCAFE);
      fwd(2, 6);
      chk("R8 Inv in SI_A", {rsp_valid, rsp_kind, rsp_dest, line_state}, {2'b11, 4'd6, 4'd10});
      fwd(3, 0);
      chk("R7 PutAck", {line_state, free_line}, {4'd0, 1'b1});
   endtask

   task automatic t_evict_s;
      cpu(0);
      resp(0, 0, 64'h5);
      cpu(2);
      chk("R7 PutS", {req_valid, req_kind, req_has_data, line_state}, {1'b1, 2'd2, 1'b0, 4'd9});
      chk("R12 evict on replace", evict_valid, 1);
      fwd(3, 0);
      chk("R7 PutAck from SI_A", {line_state, free_line}, {4'd0, 1'b1});
   endtask

   task automatic t_priority;
      cpu(0);
      drive(1, 0, 1, 2, 1, 0, 0, 0, 0);
      chk("R10 stalled fwd blocks cpu", {fwd_rdy_s, cpu_rdy_s}, 2'b00);
      chk("R10 nothing taken", {line_state, rsp_valid}, {4'd3, 1'b0});
      drive(0, 0, 1, 2, 1, 1, 0, 0, 64'h6);
      chk("R10 response first", {line_state, rsp_valid}, {4'd1, 1'b0});
      drive(1, 0, 1, 2, 1, 0, 0, 0, 0);
      chk("R10 fwd before cpu", {fwd_rdy_s, cpu_rdy_s}, 2'b10);
      chk("R10 only fwd taken", {line_state, rsp_valid, hit_valid}, {4'd0, 2'b10});
   endtask

   task automatic t_unexpected;
      fwd(0, 1);
      chk("R13 unexpected fwd", {proto_err, line_state, rsp_valid}, {1'b1, 4'd0, 1'b0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_miss();
      t_write_acks_after();
      t_upgrade_acks_first();
      t_upgrade_lost();
      t_evict_m();
      t_evict_s();
      t_priority();
      t_unexpected();
      @(negedge clk);
      chk("R12 disabled notices", noev_seen, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule